// File: doc/BRIEF.md
# Tearing-Synchronized Partial Frame Writer

This block drives command-mode updates to a display panel that keeps its own frame memory and refreshes itself from it. The host only sends the rectangle of the picture that changed since the last update. A software or graphics agent posts a rectangle descriptor. The block holds it until the panel's tearing-effect pulse arrives. It then opens a start window and, once the link reports ready inside that window, walks the rectangle row by row. Each row is split into segments no longer than a programmable pixel limit. For every segment the block first asks the pixel fetch path to stage the pixels. It then asks the packet layer to send them as a long memory-write packet.

When no update is pending, the block asks the link to enter its ultra-low-power state. It withdraws that request a programmable number of cycles before the next tearing pulse is expected, so the link is awake in time. If the link is not ready before the window closes, the update is not dropped. It is carried over to the next tearing pulse. A descriptor that arrives while a transfer runs waits for the next pulse. Of several descriptors posted before a pulse, the newest one is the one sent.

Top module: `te_frame_writer`

## Requirements
- R1: The tearing input passes through a two-stage synchronizer and a rising-edge detector. With a valid rectangle pending and the link ready, `fetch_req` is low after the third clock edge that samples `te_in` high and high after the fourth.
- R2: No fetch or packet request is made without a tearing rising edge, even when a rectangle is pending and the link is ready.
- R3: After a tearing edge, a transfer may start only while fewer than `cfg_win_cycles` window cycles have passed. If `link_ready` stays low until then, nothing is sent, and the same rectangle is sent after the next tearing edge.
- R4: The rectangle (x, y, width, height) is sent row by row with y ascending. Each row is sent as segments from left to right. Every segment has length `cfg_max_pix`, except the last one in a row, which carries the remainder. A limit of 0 is treated as 1. Nothing is requested after the last segment.
- R5: Every packet request carries the long-write data type code 0x39 on `pkt_dtype`.
- R6: `pkt_first` is 1 on the first packet of an update and 0 on every later packet of that update.
- R7: `ulps_req` is 1 while idle with nothing pending. With a rectangle pending, it falls once `cfg_te_period - cfg_wake_lead` cycles have passed since the last tearing edge (at once if the lead is not below the period). It stays 0 while a window or transfer is in progress.
- R8: Of several descriptors posted before a tearing edge, only the newest is sent. A descriptor posted during a transfer is not sent by that transfer. It is sent after the following tearing edge.
- R9: A descriptor with zero width or zero height is discarded. No transfer follows it, and `ulps_req` stays 1.
- R10: For each segment, `fetch_req` is held with stable coordinates until `fetch_ack`. Only then is `pkt_valid` raised, on the next cycle, with the same coordinates, and held stable until `pkt_ready`.
- R11: After reset, `ulps_req` is 1 and `fetch_req` and `pkt_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| te_in | input | 1 | Asynchronous tearing-effect pulse from the panel |
| rect_valid | input | 1 | One-cycle strobe posting a new rectangle |
| rect_x | input | COORD_W | Left column of the rectangle |
| rect_y | input | COORD_W | Top row of the rectangle |
| rect_w | input | COORD_W | Rectangle width in pixels |
| rect_h | input | COORD_W | Rectangle height in rows |
| cfg_max_pix | input | COORD_W | Largest pixel count per packet |
| cfg_win_cycles | input | WIN_W | Length of the start window after a tearing edge |
| cfg_te_period | input | PER_W | Expected cycles between tearing edges |
| cfg_wake_lead | input | PER_W | Cycles ahead of the expected edge at which the link is woken |
| link_ready | input | 1 | Link is in high-speed mode and can accept traffic |
| ulps_req | output | 1 | Request for the link to enter ultra-low-power state |
| fetch_req | output | 1 | Request to stage pixels of the current segment |
| fetch_x | output | COORD_W | Segment start column |
| fetch_y | output | COORD_W | Segment row |
| fetch_len | output | COORD_W | Segment length in pixels |
| fetch_ack | input | 1 | Segment pixels are staged |
| pkt_valid | output | 1 | Packet request for the staged segment |
| pkt_ready | input | 1 | Packet layer accepts the request |
| pkt_dtype | output | 8 | Data type code of the packet |
| pkt_first | output | 1 | Packet opens a new memory write |
| pkt_x | output | COORD_W | Packet start column |
| pkt_y | output | COORD_W | Packet row |
| pkt_len | output | COORD_W | Packet length in pixels |

## Verification
The tearing path has one fixed latency. Three register stages lie between a sample of `te_in` and the window state, and one more lies between the window state and the fetch state. The start check therefore looks at `fetch_req` after exactly the third and the fourth edge, at the falling edge of the clock. Each segment handshake is checked one cycle after the acknowledge: `pkt_valid` must be up at the next falling edge, and the next segment's `fetch_req` must be up one cycle after `pkt_ready`. The wake lead passes through a counter and two registers. Its checks therefore sample well before and well after the threshold. Window expiry and the "nothing happens" cases are checked by watching the outputs for a fixed number of cycles after the stimulus.

// File: rtl/fw_pkg.sv
package fw_pkg;

  localparam logic [7:0] DT_LONG_WRITE = 8'h39;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WIN   = 2'd1,
    ST_FETCH = 2'd2,
    ST_PKT   = 2'd3
  } fw_state_e;

endpackage

// File: rtl/fw_te_sync.sv
module fw_te_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic te_async,
  output logic te_rise
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= te_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[gi] <= 1'b0;
          else     chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign te_rise = chain_q[STAGES-1] & ~prev_q;

  AST_TE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    te_rise |=> !te_rise); // R1

endmodule

// File: rtl/fw_rect_hold.sv
module fw_rect_hold #(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  input  logic [COORD_W-1:0] in_w,
  input  logic [COORD_W-1:0] in_h,
  input  logic               latch,
  input  logic               restore,
  output logic               pend_valid,
  output logic [COORD_W-1:0] act_x,
  output logic [COORD_W-1:0] act_y,
  output logic [COORD_W-1:0] act_w,
  output logic [COORD_W-1:0] act_h
);

  logic               accept;
  logic [COORD_W-1:0] pend_x, pend_y, pend_w, pend_h;

  assign accept = in_valid && (in_w != '0) && (in_h != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_x     <= '0;
      pend_y     <= '0;
      pend_w     <= '0;
      pend_h     <= '0;
    end else begin
      if (accept) begin
        pend_valid <= 1'b1;
        pend_x     <= in_x;
        pend_y     <= in_y;
        pend_w     <= in_w;
        pend_h     <= in_h;
      end else if (latch) begin
        pend_valid <= 1'b0;
      end else if (restore) begin
        pend_valid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_x <= '0;
      act_y <= '0;
      act_w <= '0;
      act_h <= '0;
    end else if (latch) begin
      act_x <= pend_x;
      act_y <= pend_y;
      act_w <= pend_w;
      act_h <= pend_h;
    end
  end

  AST_LATCH_HAS_RECT: assert property (@(posedge clk) disable iff (rst)
    latch |-> pend_valid); // R8

  AST_ZERO_RECT_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_w == '0 || in_h == '0) && !pend_valid && !restore) |=> !pend_valid); // R9

endmodule

// File: rtl/fw_seg_walk.sv
module fw_seg_walk #(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               adv,
  input  logic [COORD_W-1:0] x0_i,
  input  logic [COORD_W-1:0] y0_i,
  input  logic [COORD_W-1:0] w_i,
  input  logic [COORD_W-1:0] h_i,
  input  logic [COORD_W-1:0] max_i,
  output logic [COORD_W-1:0] seg_x,
  output logic [COORD_W-1:0] seg_y,
  output logic [COORD_W-1:0] seg_len,
  output logic               seg_last
);

  localparam int SUM_W = COORD_W + 1;

  logic [COORD_W-1:0] x0_q, y0_q, w_q, h_q, max_q;
  logic [COORD_W-1:0] col_q, row_q, len_q;
  logic               last_q;

  logic [COORD_W-1:0] eff_max;
  logic [COORD_W-1:0] ld_len;
  logic               ld_last;
  logic [SUM_W-1:0]   row_sum;
  logic               row_end;
  logic [COORD_W-1:0] n_col, n_row, n_len, n_room;
  logic               n_last;

  function automatic logic [COORD_W-1:0] min_len(input logic [COORD_W-1:0] a,
                                                 input logic [COORD_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  always_comb begin
    eff_max = (max_i == '0) ? COORD_W'(1) : max_i;
    ld_len  = min_len(eff_max, w_i);
    ld_last = (h_i == COORD_W'(1)) && (ld_len == w_i);

    row_sum = SUM_W'(col_q) + SUM_W'(len_q);
    row_end = row_sum >= SUM_W'(w_q);
    n_col   = row_end ? '0 : row_sum[COORD_W-1:0];
    n_row   = row_end ? row_q + COORD_W'(1) : row_q;
    n_room  = w_q - n_col;
    n_len   = min_len(max_q, n_room);
    n_last  = (n_row == h_q - COORD_W'(1)) &&
              ((SUM_W'(n_col) + SUM_W'(n_len)) >= SUM_W'(w_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x0_q   <= '0;
      y0_q   <= '0;
      w_q    <= '0;
      h_q    <= '0;
      max_q  <= COORD_W'(1);
      col_q  <= '0;
      row_q  <= '0;
      len_q  <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      x0_q   <= x0_i;
      y0_q   <= y0_i;
      w_q    <= w_i;
      h_q    <= h_i;
      max_q  <= eff_max;
      col_q  <= '0;
      row_q  <= '0;
      len_q  <= ld_len;
      last_q <= ld_last;
    end else if (adv) begin
      col_q  <= n_col;
      row_q  <= n_row;
      len_q  <= n_len;
      last_q <= n_last;
    end
  end

  assign seg_x    = x0_q + col_q;
  assign seg_y    = y0_q + row_q;
  assign seg_len  = len_q;
  assign seg_last = last_q;

  AST_SEG_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    adv |=> (seg_len <= max_q) && (seg_len != '0)); // R4

  AST_ROW_ORDER: assert property (@(posedge clk) disable iff (rst)
    adv |=> (row_q == $past(row_q)) || (row_q == $past(row_q) + COORD_W'(1))); // R4

endmodule

// File: rtl/fw_wake_timer.sv
module fw_wake_timer #(
  parameter int PER_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             te_rise,
  input  logic [PER_W-1:0] period_i,
  input  logic [PER_W-1:0] lead_i,
  output logic             wake_zone
);

  localparam logic [PER_W-1:0] CNT_MAX = '1;

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] thresh;

  assign thresh = (period_i > lead_i) ? (period_i - lead_i) : '0;

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= CNT_MAX;
    else if (te_rise)         cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + PER_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) wake_zone <= 1'b0;
    else     wake_zone <= (cnt_q >= thresh);
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    te_rise |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/te_frame_writer.sv
module te_frame_writer #(
  parameter int COORD_W     = 12,
  parameter int WIN_W       = 10,
  parameter int PER_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               te_in,
  input  logic               rect_valid,
  input  logic [COORD_W-1:0] rect_x,
  input  logic [COORD_W-1:0] rect_y,
  input  logic [COORD_W-1:0] rect_w,
  input  logic [COORD_W-1:0] rect_h,
  input  logic [COORD_W-1:0] cfg_max_pix,
  input  logic [WIN_W-1:0]   cfg_win_cycles,
  input  logic [PER_W-1:0]   cfg_te_period,
  input  logic [PER_W-1:0]   cfg_wake_lead,
  input  logic               link_ready,
  output logic               ulps_req,
  output logic               fetch_req,
  output logic [COORD_W-1:0] fetch_x,
  output logic [COORD_W-1:0] fetch_y,
  output logic [COORD_W-1:0] fetch_len,
  input  logic               fetch_ack,
  output logic               pkt_valid,
  input  logic               pkt_ready,
  output logic [7:0]         pkt_dtype,
  output logic               pkt_first,
  output logic [COORD_W-1:0] pkt_x,
  output logic [COORD_W-1:0] pkt_y,
  output logic [COORD_W-1:0] pkt_len
);

  import fw_pkg::*;

  fw_state_e        state_q, state_d;
  logic [WIN_W-1:0] win_q;
  logic             first_q;
  logic             ulps_q;

  logic               te_rise;
  logic               pend_valid;
  logic               wake_zone;
  logic               latch, restore, go, expire, seg_done;
  logic [COORD_W-1:0] act_x, act_y, act_w, act_h;
  logic [COORD_W-1:0] seg_x, seg_y, seg_len;
  logic               seg_last;

  fw_te_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .te_async (te_in),
    .te_rise  (te_rise)
  );

  fw_rect_hold #(.COORD_W(COORD_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (rect_valid),
    .in_x       (rect_x),
    .in_y       (rect_y),
    .in_w       (rect_w),
    .in_h       (rect_h),
    .latch      (latch),
    .restore    (restore),
    .pend_valid (pend_valid),
    .act_x      (act_x),
    .act_y      (act_y),
    .act_w      (act_w),
    .act_h      (act_h)
  );

  fw_seg_walk #(.COORD_W(COORD_W)) u_walk (
    .clk      (clk),
    .rst      (rst),
    .load     (go),
    .adv      (seg_done && !seg_last),
    .x0_i     (act_x),
    .y0_i     (act_y),
    .w_i      (act_w),
    .h_i      (act_h),
    .max_i    (cfg_max_pix),
    .seg_x    (seg_x),
    .seg_y    (seg_y),
    .seg_len  (seg_len),
    .seg_last (seg_last)
  );

  fw_wake_timer #(.PER_W(PER_W)) u_wake (
    .clk       (clk),
    .rst       (rst),
    .te_rise   (te_rise),
    .period_i  (cfg_te_period),
    .lead_i    (cfg_wake_lead),
    .wake_zone (wake_zone)
  );

  // Control decode from the registered state.
  assign latch    = (state_q == ST_IDLE) && te_rise && pend_valid;
  assign go       = (state_q == ST_WIN) && link_ready && (win_q < cfg_win_cycles);
  assign expire   = (state_q == ST_WIN) && !go && (win_q >= cfg_win_cycles);
  assign restore  = expire;
  assign seg_done = (state_q == ST_PKT) && pkt_ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (latch)                state_d = ST_WIN;
      ST_WIN:   if (go)                   state_d = ST_FETCH;
                else if (expire)          state_d = ST_IDLE;
      ST_FETCH: if (fetch_ack)            state_d = ST_PKT;
      ST_PKT:   if (pkt_ready)            state_d = seg_last ? ST_IDLE : ST_FETCH;
      default:                            state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
      first_q <= 1'b0;
      ulps_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      if (latch)                          win_q <= '0;
      else if (state_q == ST_WIN)         win_q <= win_q + WIN_W'(1);
      if (go)                             first_q <= 1'b1;
      else if (seg_done)                  first_q <= 1'b0;
      ulps_q <= (state_q == ST_IDLE) && !latch && !(pend_valid && wake_zone);
    end
  end

  assign ulps_req  = ulps_q;
  assign fetch_req = (state_q == ST_FETCH);
  assign fetch_x   = seg_x;
  assign fetch_y   = seg_y;
  assign fetch_len = seg_len;
  assign pkt_valid = (state_q == ST_PKT);
  assign pkt_dtype = DT_LONG_WRITE;
  assign pkt_first = pkt_valid && first_q;
  assign pkt_x     = seg_x;
  assign pkt_y     = seg_y;
  assign pkt_len   = seg_len;

  AST_WIN_AFTER_TE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WIN && $past(state_q) != ST_WIN) |-> $past(te_rise)); // R1

  AST_NO_START_LATE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WIN && win_q >= cfg_win_cycles) |=> !fetch_req); // R3

  AST_FETCH_AWAKE: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> !ulps_req); // R7

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && !fetch_ack) |=> fetch_req && $stable(fetch_x) && $stable(fetch_y) && $stable(fetch_len)); // R10

  AST_PKT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_ready) |=> pkt_valid && $stable(pkt_x) && $stable(pkt_y) && $stable(pkt_len) && $stable(pkt_first)); // R10

  AST_PKT_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(pkt_valid) |-> $past(fetch_req && fetch_ack)); // R10

  AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_ready) |=> !pkt_first); // R6

endmodule

// File: tb/te_frame_writer_bench.sv
module te_frame_writer_bench;

  localparam int CW = 8;
  localparam int WW = 8;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          te_in = 1'b0;
  logic          rect_valid = 1'b0;
  logic [CW-1:0] rect_x = '0, rect_y = '0, rect_w = '0, rect_h = '0;
  logic [CW-1:0] cfg_max_pix = CW'(4);
  logic [WW-1:0] cfg_win_cycles = WW'(6);
  logic [PW-1:0] cfg_te_period = PW'(200);
  logic [PW-1:0] cfg_wake_lead = PW'(200);
  logic          link_en = 1'b1;
  logic          link_ready;
  logic          ulps_req, fetch_req, fetch_ack = 1'b0, pkt_valid, pkt_ready = 1'b0;
  logic [CW-1:0] fetch_x, fetch_y, fetch_len, pkt_x, pkt_y, pkt_len;
  logic [7:0]    pkt_dtype;
  logic          pkt_first;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  assign link_ready = link_en & ~ulps_req;

  te_frame_writer #(.COORD_W(CW), .WIN_W(WW), .PER_W(PW), .SYNC_STAGES(2)) u_te_frame_writer (
    .clk(clk), .rst(rst), .te_in(te_in),
    .rect_valid(rect_valid), .rect_x(rect_x), .rect_y(rect_y), .rect_w(rect_w), .rect_h(rect_h),
    .cfg_max_pix(cfg_max_pix), .cfg_win_cycles(cfg_win_cycles),
    .cfg_te_period(cfg_te_period), .cfg_wake_lead(cfg_wake_lead),
    .link_ready(link_ready), .ulps_req(ulps_req),
    .fetch_req(fetch_req), .fetch_x(fetch_x), .fetch_y(fetch_y), .fetch_len(fetch_len),
    .fetch_ack(fetch_ack), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_dtype(pkt_dtype), .pkt_first(pkt_first), .pkt_x(pkt_x), .pkt_y(pkt_y), .pkt_len(pkt_len)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  task automatic post(input int x, input int y, input int w, input int h);
    @(negedge clk);
    rect_x = CW'(x); rect_y = CW'(y); rect_w = CW'(w); rect_h = CW'(h);
    rect_valid = 1'b1;
    @(negedge clk);
    rect_valid = 1'b0;
  endtask

  task automatic pulse_te();
    @(negedge clk);
    te_in = 1'b1;
    repeat (3) @(negedge clk);
    te_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Watches for a quiet bus over n cycles; returns count of cycles with any request.
  task automatic quiet(input int n, output int busy);
    busy = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fetch_req || pkt_valid) busy++;
    end
  endtask

  // Serves one update and compares each segment with the arithmetic expectation.
  task automatic serve(input int x0, input int y0, input int w, input int h, input int mx);
    int  eff;
    int  len;
    int  wait_n;
    bit  first;
    eff = (mx == 0) ? 1 : mx;
    first = 1'b1;
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c += eff) begin
        len = (w - c < eff) ? (w - c) : eff;
        wait_n = 0;
        while (!fetch_req && wait_n < 60) begin
          @(negedge clk);
          wait_n++;
        end
        check(fetch_req === 1'b1, "R4 fetch present", int'(fetch_req), 1);
        check(fetch_x == CW'(x0 + c) && fetch_y == CW'(y0 + r) && fetch_len == CW'(len),
              "R4 segment", int'(fetch_x) * 65536 + int'(fetch_y) * 256 + int'(fetch_len),
              (x0 + c) * 65536 + (y0 + r) * 256 + len);
        check(pkt_valid === 1'b0, "R10 no packet before ack", int'(pkt_valid), 0);
        fetch_ack = 1'b1;
        @(negedge clk);
        fetch_ack = 1'b0;
        check(pkt_valid === 1'b1 && pkt_x == CW'(x0 + c) && pkt_y == CW'(y0 + r) && pkt_len == CW'(len),
              "R10 packet follows ack", int'(pkt_x) * 256 + int'(pkt_len), (x0 + c) * 256 + len);
        check(pkt_dtype == 8'h39, "R5 data type", int'(pkt_dtype), 57);
        check(pkt_first == first, "R6 first flag", int'(pkt_first), int'(first));
        @(negedge clk);
        check(pkt_valid === 1'b1 && pkt_x == CW'(x0 + c), "R10 packet held", int'(pkt_valid), 1);
        pkt_ready = 1'b1;
        @(negedge clk);
        pkt_ready = 1'b0;
        first = 1'b0;
      end
    end
    @(negedge clk);
    check(!fetch_req && !pkt_valid, "R4 nothing after last segment",
          int'(fetch_req) + int'(pkt_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int busy;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(ulps_req === 1'b1 && fetch_req === 1'b0 && pkt_valid === 1'b0, "R11 reset state",
          int'(ulps_req) * 4 + int'(fetch_req) * 2 + int'(pkt_valid), 4);

    // R2: pending rectangle, link ready, no tearing edge
    post(5, 6, 3, 2);
    quiet(40, busy);
    check(busy == 0, "R2 no start without TE", busy, 0);

    // R1: exact start latency from the tearing input
    @(negedge clk);
    te_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(fetch_req === 1'b0, "R1 not yet after third edge", int'(fetch_req), 0);
    @(posedge clk);
    @(negedge clk);
    check(fetch_req === 1'b1, "R1 start after fourth edge", int'(fetch_req), 1);
    te_in = 1'b0;
    serve(5, 6, 3, 2, 4);

    // R4 R5 R6 R10: sweep of shapes and packet limits
    for (int mi = 0; mi < 4; mi++) begin
      for (int w = 1; w <= 9; w++) begin
        for (int h = 1; h <= 3; h++) begin
          int mx;
          mx = (mi == 0) ? 1 : (mi == 1) ? 3 : (mi == 2) ? 4 : 0;
          cfg_max_pix = CW'(mx);
          post(10 + w, 20 + h, w, h);
          pulse_te();
          serve(10 + w, 20 + h, w, h, mx);
        end
      end
    end
    cfg_max_pix = CW'(4);

    // R3: window expires with the link held down, then carry-over
    link_en = 1'b0;
    post(2, 3, 6, 1);
    pulse_te();
    quiet(30, busy);
    check(busy == 0, "R3 no start after window", busy, 0);
    link_en = 1'b1;
    quiet(30, busy);
    check(busy == 0, "R3 deferred waits for next TE", busy, 0);
    pulse_te();
    serve(2, 3, 6, 1, 4);

    // R8: newest of two descriptors wins; one posted mid-transfer waits
    post(1, 1, 2, 1);
    post(7, 8, 5, 2);
    pulse_te();
    while (!fetch_req) @(negedge clk);
    post(30, 40, 3, 1);
    serve(7, 8, 5, 2, 4);
    quiet(30, busy);
    check(busy == 0, "R8 mid-transfer rectangle not sent early", busy, 0);
    pulse_te();
    serve(30, 40, 3, 1, 4);

    // R9: zero-sized descriptors are dropped
    post(4, 4, 0, 3);
    post(4, 4, 3, 0);
    repeat (3) @(negedge clk);
    check(ulps_req === 1'b1, "R9 link stays asleep", int'(ulps_req), 1);
    pulse_te();
    quiet(30, busy);
    check(busy == 0, "R9 no transfer for empty rectangle", busy, 0);

    // R7: wake request placed ahead of the expected edge
    cfg_te_period = PW'(100);
    cfg_wake_lead = PW'(30);
    pulse_te();
    check(ulps_req === 1'b1, "R7 idle asleep", int'(ulps_req), 1);
    post(9, 9, 4, 1);
    repeat (30) @(negedge clk);
    check(ulps_req === 1'b1, "R7 still asleep before lead point", int'(ulps_req), 1);
    repeat (60) @(negedge clk);
    check(ulps_req === 1'b0, "R7 awake past lead point", int'(ulps_req), 0);
    pulse_te();
    check(ulps_req === 1'b0, "R7 awake during transfer", int'(ulps_req), 0);
    serve(9, 9, 4, 1, 4);
    repeat (3) @(negedge clk);
    check(ulps_req === 1'b1, "R7 asleep after update", int'(ulps_req), 1);

    summary();
    $finish;
  end

endmodule